// File: doc/BRIEF.md
# Shared EDID Image Server for Four Display Ports

This block lets four display inputs read one 256-byte EDID image that sits in a single on-chip single-port memory. Each port has its own request, byte address and data-valid pulse. The block arbitrates between the ports in rotating order and serves one byte read at a time. For each read it fetches the vendor-specific data block (VSDB) fields it needs, then the requested byte.

The stored VSDB does not hold the registration identifier in its three identifier bytes. Those bytes hold a nibble for each port and a field-select nibble. The block always returns the fixed identifier in those positions. It builds each port's physical address from the stored default fields, with the port's own nibble substituted in. It also returns to each port a checksum byte corrected for that port's substituted address. The stored checksum is computed with the fixed identifier and the default address fields.

`vsdb_base` gives the offset of the VSDB tag byte. The identifier bytes sit at offsets +1..+3 and the address bytes at +4 and +5.

Top module: `edid_port_server`

## Requirements
- R1: Each port p (0..3) holds `req[p]` high and its address `port_addr[8p+7:8p]` stable until it sees `rd_valid[p]`. `rd_valid[p]` is a single-cycle pulse. `rd_data[8p+7:8p]` changes only in the cycle `rd_valid[p]` rises, and it keeps the served byte afterwards.
- R2: A byte outside VSDB offsets +1..+5 and not at the checksum address is returned exactly as stored.
- R3: Reads at VSDB offsets +1, +2 and +3 return 0x03, 0x0C and 0x00 respectively, whatever is stored there.
- R4: The stored identifier bytes are decoded as follows. Offset +1 holds {port 0 nibble [7:4], port 1 nibble [3:0]}. Offset +2 holds {port 2 nibble, port 3 nibble}. Bits [3:0] of offset +3 hold the field select, and bits [7:4] are ignored.
- R5: Select bit 3 replaces W (offset +4 bits [7:4]), bit 2 replaces X (+4 bits [3:0]), bit 1 replaces Y (+5 bits [7:4]) and bit 0 replaces Z (+5 bits [3:0]) with the reading port's nibble. Each set bit replaces its field. A select of 0000 returns the defaults.
- R6: A read of the checksum address (0xFF by default) returns a value that makes bytes 128..255, as served to that port, sum to 0 modulo 256.
- R7: Only one read is in service at a time. With several ports waiting, the grant goes to the next requesting port after the last one served, in rotating order 0,1,2,3. A port is not granted again in the cycle its `rd_valid` is high.
- R8: After reset all `rd_valid` bits are 0 and all `rd_data` bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsdb_base | input | 8 | Offset of the VSDB tag byte in the image |
| req | input | 4 | Per-port read request |
| port_addr | input | 32 | Per-port byte address, port p in bits [8p+7:8p] |
| mem_addr | output | 8 | Image memory read address |
| mem_rdata | input | 8 | Image memory read data, one cycle after the address |
| rd_valid | output | 4 | Per-port data-valid pulse |
| rd_data | output | 32 | Per-port served byte, port p in bits [8p+7:8p] |

## Verification
The hardest case to reach from the ports is all four ports waiting at once, each for a byte whose value depends on its own nibble. The arbiter order and the per-port substitution both have to come out right under that contention. The bench forks four drivers that raise their requests on the same edge and keep re-requesting identifier, address and checksum bytes. It logs the order of completions and checks that the order rotates. The override select is rewritten between phases to cover the W, Z, none and two-field cases. One port then reads the whole upper block so that the bench can check the sum of the bytes it receives.

// File: rtl/edid_port_server.sv
module edid_port_server #(
  parameter logic [7:0] CSUM_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  vsdb_base,
  input  logic [3:0]  req,
  input  logic [31:0] port_addr,
  output logic [7:0]  mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [3:0]  rd_valid,
  output logic [31:0] rd_data
);
  localparam logic [2:0] FETCH_TGT = 3'd5;
  localparam logic [2:0] DONE_STEP = 3'd6;

  logic       busy;
  logic [2:0] step;
  logic [1:0] cur, last, nxt, idx;
  logic       found;
  logic [7:0] t_addr, ovr_ab, ovr_cd, def4, def5;
  logic [3:0] sel, nib;
  logic [7:0] n4, n5, off, result;
  logic [7:0] dout [4];

  always_comb begin
    found = 1'b0;
    nxt   = last;
    idx   = last;
    for (int i = 1; i <= 4; i++) begin
      idx = last + 2'(i);
      if (!found && req[idx] && !rd_valid[idx]) begin
        found = 1'b1;
        nxt   = idx;
      end
    end
  end

  assign mem_addr = (step >= FETCH_TGT) ? t_addr : vsdb_base + 8'(step) + 8'd1;

  always_comb begin
    case (cur)
      2'd0:    nib = ovr_ab[7:4];
      2'd1:    nib = ovr_ab[3:0];
      2'd2:    nib = ovr_cd[7:4];
      default: nib = ovr_cd[3:0];
    endcase
  end

  assign n4  = {sel[3] ? nib : def4[7:4], sel[2] ? nib : def4[3:0]};
  assign n5  = {sel[1] ? nib : def5[7:4], sel[0] ? nib : def5[3:0]};
  assign off = t_addr - vsdb_base;

  always_comb begin
    if (off == 8'd1)                result = 8'h03;
    else if (off == 8'd2)           result = 8'h0C;
    else if (off == 8'd3)           result = 8'h00;
    else if (off == 8'd4)           result = n4;
    else if (off == 8'd5)           result = n5;
    else if (t_addr == CSUM_ADDR)   result = mem_rdata - (n4 - def4) - (n5 - def5);
    else                            result = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      cur      <= '0;
      last     <= 2'd3;
      t_addr   <= '0;
      ovr_ab   <= '0;
      ovr_cd   <= '0;
      sel      <= '0;
      def4     <= '0;
      def5     <= '0;
      rd_valid <= '0;
      for (int i = 0; i < 4; i++) dout[i] <= '0;
    end else begin
      rd_valid <= '0;
      if (!busy) begin
        if (found) begin
          busy   <= 1'b1;
          step   <= '0;
          cur    <= nxt;
          last   <= nxt;
          t_addr <= port_addr[{nxt, 3'b000} +: 8];
        end
      end else begin
        step <= step + 3'd1;
        case (step)
          3'd1: ovr_ab <= mem_rdata;
          3'd2: ovr_cd <= mem_rdata;
          3'd3: sel    <= mem_rdata[3:0];
          3'd4: def4   <= mem_rdata;
          3'd5: def5   <= mem_rdata;
          DONE_STEP: begin
            dout[cur]     <= result;
            rd_valid[cur] <= 1'b1;
            busy          <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_out
    assign rd_data[g*8 +: 8] = dout[g];
  end
endmodule

// File: rtl/edid_port_server_chk.sv
module edid_port_server_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  vsdb_base,
  input logic [3:0]  req,
  input logic [31:0] port_addr,
  input logic [3:0]  rd_valid,
  input logic [31:0] rd_data
);
  // R7
  one_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_valid));

  for (genvar g = 0; g < 4; g++) begin : g_port
    // R1
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[g] |=> !rd_valid[g]);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[g] |-> $stable(rd_data[g*8 +: 8]));
    // R7
    granted_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[g] |-> $past(req[g]));
    // R3
    ident_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[g] && port_addr[g*8 +: 8] == vsdb_base + 8'd1) |-> rd_data[g*8 +: 8] == 8'h03);
    // R3
    ident_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[g] && port_addr[g*8 +: 8] == vsdb_base + 8'd2) |-> rd_data[g*8 +: 8] == 8'h0C);
  end
endmodule

bind edid_port_server edid_port_server_chk u_chk (.*);

// File: tb/edid_port_server_bench.sv
module edid_port_server_bench;
  localparam logic [7:0] BASE = 8'h90;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  pa [4] = '{default: 8'h00};
  logic [31:0] port_addr;
  logic [7:0]  mem_addr, mem_rdata;
  logic [3:0]  rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  mem [256];

  int checks = 0, fails = 0;
  logic [7:0] exp_q [4][$];
  string      tag_q [4][$];
  int         order [$];

  always #2.5 clk = ~clk;
  assign port_addr = {pa[3], pa[2], pa[1], pa[0]};

  always @(posedge clk) mem_rdata <= mem[mem_addr];

  edid_port_server u_edid_port_server (
    .clk(clk), .rst_n(rst_n), .vsdb_base(BASE), .req(req), .port_addr(port_addr),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", t, act, exp);
    end
  endtask

  function automatic logic [7:0] served(input int p, input logic [7:0] a);
    logic [7:0] off, d4, d5;
    logic [3:0] nib, sel;
    off = a - BASE;
    d4  = mem[8'(BASE + 8'd4)];
    d5  = mem[8'(BASE + 8'd5)];
    sel = mem[8'(BASE + 8'd3)][3:0];
    case (p)
      0: nib = mem[8'(BASE + 8'd1)][7:4];
      1: nib = mem[8'(BASE + 8'd1)][3:0];
      2: nib = mem[8'(BASE + 8'd2)][7:4];
      default: nib = mem[8'(BASE + 8'd2)][3:0];
    endcase
    if (off == 1) return 8'h03;
    if (off == 2) return 8'h0C;
    if (off == 3) return 8'h00;
    if (off == 4) return {sel[3] ? nib : d4[7:4], sel[2] ? nib : d4[3:0]};
    if (off == 5) return {sel[1] ? nib : d5[7:4], sel[0] ? nib : d5[3:0]};
    return mem[a];
  endfunction

  function automatic logic [7:0] exp_byte(input int p, input logic [7:0] a);
    logic [7:0] s;
    if (a != 8'hFF) return served(p, a);
    s = 8'h00;
    for (int j = 128; j < 255; j++) s = s + served(p, 8'(j));
    return 8'h00 - s;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    logic [7:0] off;
    off = a - BASE;
    if (off >= 1 && off <= 3) return "R3";
    if (off == 4 || off == 5) return "R5";
    if (a == 8'hFF) return "R6";
    return "R2";
  endfunction

  task automatic fix_csum();
    logic [7:0] s;
    s = 8'h00;
    for (int j = 128; j < 255; j++) begin
      if (j == 8'h91) s = s + 8'h03;
      else if (j == 8'h92) s = s + 8'h0C;
      else if (j == 8'h93) s = s + 8'h00;
      else s = s + mem[j];
    end
    mem[255] = 8'h00 - s;
  endtask

  task automatic rd(input int p, input logic [7:0] a, output logic [7:0] d);
    exp_q[p].push_back(exp_byte(p, a));
    tag_q[p].push_back(tag_of(a));
    pa[p]  = a;
    req[p] = 1'b1;
    do @(negedge clk); while (!rd_valid[p]);
    d = rd_data[p*8 +: 8];
    req[p] = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_set(input int p);
    logic [7:0] d;
    rd(p, 8'h91, d); rd(p, 8'h92, d); rd(p, 8'h93, d);
    rd(p, 8'h94, d); rd(p, 8'h95, d); rd(p, 8'hFF, d);
  endtask

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst_n && rd_valid[i]) begin
        order.push_back(i);
        if (exp_q[i].size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 port %0d actual=unexpected valid expected=none", i);
        end else begin
          check($sformatf("%s port %0d", tag_q[i].pop_front(), i), rd_data[i*8 +: 8], exp_q[i].pop_front());
        end
      end
    end
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, s;
    for (int j = 0; j < 256; j++) mem[j] = 8'(j * 7 + 3);
    mem[8'h90] = 8'h65;
    mem[8'h91] = 8'h12;
    mem[8'h92] = 8'h34;
    mem[8'h93] = 8'hA8;
    mem[8'h94] = 8'h10;
    mem[8'h95] = 8'h00;
    fix_csum();
    repeat (3) @(negedge clk);
    // R8
    check("R8 valid", {4'h0, rd_valid}, 8'h00);
    check("R8 data", rd_data[7:0] | rd_data[15:8] | rd_data[23:16] | rd_data[31:24], 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: select W (bit 3), upper select bits set and ignored
    for (int p = 0; p < 4; p++) rd_set(p);
    // R2: plain bytes
    rd(0, 8'h00, d); rd(1, 8'h50, d); rd(2, 8'h8F, d); rd(3, 8'h96, d); rd(0, 8'hFE, d);

    // R5: select Z only
    mem[8'h93] = 8'h01; fix_csum();
    for (int p = 0; p < 4; p++) rd_set(p);
    // R5: no select
    mem[8'h93] = 8'h00; fix_csum();
    rd_set(1); rd_set(3);
    // R5: two fields
    mem[8'h93] = 8'h06; mem[8'h94] = 8'hAB; mem[8'h95] = 8'hCD; fix_csum();
    rd_set(0); rd_set(2);

    // R7: all four contend
    mem[8'h93] = 8'h08; fix_csum();
    order.delete();
    fork
      rd_set(0);
      rd_set(1);
      rd_set(2);
      rd_set(3);
    join
    for (int k = 1; k < order.size(); k++)
      check("R7 rotation", 8'(order[k]), 8'((order[k-1] + 1) % 4));
    check("R7 count", 8'(order.size()), 8'd24);

    // R6: whole upper block sums to zero for port 2
    mem[8'h93] = 8'h02; fix_csum();
    s = 8'h00;
    for (int j = 128; j < 256; j++) begin
      rd(2, 8'(j), d);
      s = s + d;
    end
    check("R6 block sum", s, 8'h00);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule